// File: doc/BRIEF.md
# OTP Fuse Array Controller

This block fronts a one-time-programmable fuse array that holds a parameterised number of 32-bit words. Software controls it through a bank of 32-bit registers on a simple valid/write/address/data bus. The registers are a word address, a bit selector, a data-in bit, three enables that must all be on before a fuse word may be read, a program-enable, a redundancy-select flag, and several test and timing registers that only store what is written to them.

Fuses are programmed one bit at a time. A write to the program-enable register with its low bit set, while the redundancy-select register is zero, copies the data-in bit into the selected bit of the selected word. A shadow bitmap records which bits have been programmed. A second attempt on a recorded bit is refused, and the block raises a one-cycle error pulse. After reset, an initialisation sweep sets every word to all ones and clears every flag. The sweep also places a serial number at a fixed word, with its bitwise inverse in the word that follows.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every register reads zero. An initialisation sweep then runs for NUM_WORDS cycles. During the sweep, bus writes are ignored and the data-out register reads 0x000000FF. Once the sweep is done, every fuse word reads 0xFFFFFFFF unless R2 says otherwise.
- R2: After the sweep, word SERIAL_IDX reads SERIAL_NUM and word SERIAL_IDX+1 reads the bitwise inverse of SERIAL_NUM.
- R3: The data-out register (offset 0x18) returns the fuse word at the stored address only when bit 0 of the chip-enable (0x0C), strobe (0x1C) and trim (0x34) registers are all 1. Otherwise it returns 0x000000FF.
- R4: A write to the program-enable register (0x38) with data bit 0 = 1, while the redundancy-select register (0x08) reads zero, sets bit (bit selector, 0x04) of word (address, 0x00) to bit 0 of the data-in register (0x14). All other bits of the array keep their values.
- R5: A program attempt on a bit whose written flag is set leaves the word unchanged. It drives prog_err high for exactly the cycle that follows the write's clock edge. prog_err is low at all other times.
- R6: Written flags are kept per bit. Once a bit is programmed, its own flag is set. Other bits of the same word, and the same bit of other words, can still be programmed.
- R7: The program-enable register stores only bit 0 of the written data. A write with bit 0 = 0 programs nothing. A write with bit 0 = 1 while redundancy-select is nonzero also programs nothing, and neither write sets a flag.
- R8: The data-out register is read-only. Writes to it change no register and no fuse.
- R9: The address register keeps only its low log2(NUM_WORDS) bits of written data. The bit-selector register keeps only its low 5 bits.
- R10: Reads of an offset that is misaligned (bits 1:0 nonzero) or beyond 0x38 return zero. Writes to such an offset change nothing.
- R11: A read returns its data, with bus_rvalid high, in the cycle after the request edge. bus_rvalid is high only in those cycles. Plain storage registers (clock 0x10, program-pulse 0x20, test registers 0x24 to 0x30) read back all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| prog_err | output | 1 | Pulse on a refused re-program attempt |

## Verification
Several properties are checked on every cycle by embedded assertions:
- read responses always follow one cycle after the request;
- a closed data-out read yields 0xFF and an unmapped read yields zero;
- writes during the sweep, to data-out, or to unmapped offsets leave the registers untouched;
- a committed program sets the chosen bit to the data-in value, sets its flag and touches no other bit of the word;
- a refused attempt freezes both the word and its flags.

Some behaviours can only be shown by the directed scenarios:
- the contents left by the sweep, including the serial pair;
- the masking of address and bit selector;
- the independence of flags across bits and words;
- the absence of any effect from a cleared enable bit or a nonzero redundancy-select.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int REG_W     = 32;
    localparam int BIT_SEL_W = 5;
    localparam logic [REG_W-1:0] DOUT_CLOSED = 32'h0000_00FF;

    typedef enum logic [3:0] {
        RS_ADDR   = 4'd0,
        RS_BITSEL = 4'd1,
        RS_REDSEL = 4'd2,
        RS_CHIPEN = 4'd3,
        RS_CLOCK  = 4'd4,
        RS_DIN    = 4'd5,
        RS_DOUT   = 4'd6,
        RS_STROBE = 4'd7,
        RS_PPULSE = 4'd8,
        RS_TCTRL  = 4'd9,
        RS_TMODE  = 4'd10,
        RS_TMREP  = 4'd11,
        RS_TREAD  = 4'd12,
        RS_TRIM   = 4'd13,
        RS_PROGEN = 4'd14,
        RS_NONE   = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] bitsel;
        logic [REG_W-1:0] redsel;
        logic [REG_W-1:0] chipen;
        logic [REG_W-1:0] clock;
        logic [REG_W-1:0] din;
        logic [REG_W-1:0] strobe;
        logic [REG_W-1:0] ppulse;
        logic [REG_W-1:0] tctrl;
        logic [REG_W-1:0] tmode;
        logic [REG_W-1:0] tmrep;
        logic [REG_W-1:0] tread;
        logic [REG_W-1:0] trim;
        logic [REG_W-1:0] progen;
    } ctrl_regs_t;

    // Map a byte offset onto a register; misaligned or out-of-range -> RS_NONE.
    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        if (off[1:0] != 2'b00 || off[31:6] != '0) begin
            return RS_NONE;
        end
        return reg_sel_e'(off[5:2]);
    endfunction

    // Value a word receives during the post-reset sweep.
    function automatic logic [REG_W-1:0] sweep_word(input logic [31:0] idx,
                                                    input logic [31:0] serial_idx,
                                                    input logic [REG_W-1:0] serial);
        if (idx == serial_idx)           return serial;
        if (idx == serial_idx + 32'd1)   return ~serial;
        return '1;
    endfunction

endpackage

// File: rtl/otp_regfile.sv
module otp_regfile
    import otp_pkg::*;
#(
    parameter int BUS_AW = 8,
    parameter int IDX_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  fuse_word,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    output logic              prog_req,
    output logic [IDX_W-1:0]  prog_idx,
    output logic [BIT_SEL_W-1:0] prog_bit,
    output logic              prog_val
);

    localparam logic [REG_W-1:0] ADDR_MASK = REG_W'((64'd1 << IDX_W) - 64'd1);
    localparam logic [REG_W-1:0] BIT_MASK  = REG_W'((1 << BIT_SEL_W) - 1);

    ctrl_regs_t       regs;
    reg_sel_e         sel;
    logic             wr_en;
    logic             rd_en;
    logic             dout_open;
    logic [REG_W-1:0] rd_mux;

    assign sel   = decode_offset(32'(bus_addr));
    assign wr_en = bus_valid && bus_write && !busy;
    assign rd_en = bus_valid && !bus_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            case (sel)
                RS_ADDR:   regs.addr   <= bus_wdata & ADDR_MASK;
                RS_BITSEL: regs.bitsel <= bus_wdata & BIT_MASK;
                RS_REDSEL: regs.redsel <= bus_wdata;
                RS_CHIPEN: regs.chipen <= bus_wdata;
                RS_CLOCK:  regs.clock  <= bus_wdata;
                RS_DIN:    regs.din    <= bus_wdata;
                RS_STROBE: regs.strobe <= bus_wdata;
                RS_PPULSE: regs.ppulse <= bus_wdata;
                RS_TCTRL:  regs.tctrl  <= bus_wdata;
                RS_TMODE:  regs.tmode  <= bus_wdata;
                RS_TMREP:  regs.tmrep  <= bus_wdata;
                RS_TREAD:  regs.tread  <= bus_wdata;
                RS_TRIM:   regs.trim   <= bus_wdata;
                RS_PROGEN: regs.progen <= {{(REG_W-1){1'b0}}, bus_wdata[0]};
                default:   ;
            endcase
        end
    end

    // A program strike is the act of writing the enable bit itself.
    assign prog_req = wr_en && (sel == RS_PROGEN) && bus_wdata[0] && (regs.redsel == '0);
    assign prog_idx = regs.addr[IDX_W-1:0];
    assign prog_bit = regs.bitsel[BIT_SEL_W-1:0];
    assign prog_val = regs.din[0];

    assign dout_open = regs.chipen[0] && regs.strobe[0] && regs.trim[0] && !busy;

    always_comb begin
        case (sel)
            RS_ADDR:   rd_mux = regs.addr;
            RS_BITSEL: rd_mux = regs.bitsel;
            RS_REDSEL: rd_mux = regs.redsel;
            RS_CHIPEN: rd_mux = regs.chipen;
            RS_CLOCK:  rd_mux = regs.clock;
            RS_DIN:    rd_mux = regs.din;
            RS_DOUT:   rd_mux = dout_open ? fuse_word : DOUT_CLOSED;
            RS_STROBE: rd_mux = regs.strobe;
            RS_PPULSE: rd_mux = regs.ppulse;
            RS_TCTRL:  rd_mux = regs.tctrl;
            RS_TMODE:  rd_mux = regs.tmode;
            RS_TMREP:  rd_mux = regs.tmrep;
            RS_TREAD:  rd_mux = regs.tread;
            RS_TRIM:   rd_mux = regs.trim;
            RS_PROGEN: rd_mux = regs.progen;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= rd_mux;
        end
    end

    AST_READ_RESP: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> bus_rvalid); // R11
    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !bus_rvalid); // R11
    AST_DOUT_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == RS_DOUT && !(regs.chipen[0] && regs.strobe[0] && regs.trim[0]))
        |=> (bus_rdata == DOUT_CLOSED)); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == RS_NONE) |=> (bus_rdata == '0)); // R10
    AST_SWEEP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_valid && bus_write) |=> $stable(regs)); // R1
    AST_DOUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && sel == RS_DOUT) |=> $stable(regs)); // R8
    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && sel == RS_NONE) |=> $stable(regs)); // R10

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
    import otp_pkg::*;
#(
    parameter int               NUM_WORDS  = 4096,
    parameter int               IDX_W      = 12,
    parameter int               SERIAL_IDX = 252,
    parameter logic [REG_W-1:0] SERIAL_NUM = 32'h5EC0_1D42
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_req,
    input  logic [IDX_W-1:0]     prog_idx,
    input  logic [BIT_SEL_W-1:0] prog_bit,
    input  logic                 prog_val,
    input  logic [IDX_W-1:0]     look_idx,
    output logic [REG_W-1:0]     look_word,
    output logic                 prog_err,
    output logic                 busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    logic [REG_W-1:0] fuse_mem [NUM_WORDS];
    logic [REG_W-1:0] flag_mem [NUM_WORDS];

    logic [IDX_W-1:0] sweep_idx;
    logic [REG_W-1:0] p_word;
    logic [REG_W-1:0] p_flags;
    logic             p_taken;
    logic             p_commit;
    logic             p_reject;

    // Post-reset sweep: one word per cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            sweep_idx <= '0;
            busy      <= 1'b1;
        end else if (busy) begin
            sweep_idx <= sweep_idx + IDX_W'(1);
            if (sweep_idx == LAST_IDX) busy <= 1'b0;
        end
    end

    assign p_word   = fuse_mem[prog_idx];
    assign p_flags  = flag_mem[prog_idx];
    assign p_taken  = p_flags[prog_bit];
    assign p_commit = prog_req && !busy && !p_taken;
    assign p_reject = prog_req && !busy && p_taken;

    always_ff @(posedge clk) begin
        if (busy) begin
            fuse_mem[sweep_idx] <= sweep_word(32'(sweep_idx), 32'(SERIAL_IDX), SERIAL_NUM);
            flag_mem[sweep_idx] <= '0;
        end else if (p_commit) begin
            fuse_mem[prog_idx][prog_bit] <= prog_val;
            flag_mem[prog_idx][prog_bit] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prog_err <= 1'b0;
        else     prog_err <= p_reject;
    end

    assign look_word = fuse_mem[look_idx];

    AST_COMMIT_VALUE: assert property (@(posedge clk) disable iff (rst)
        p_commit |=> (p_word[$past(prog_bit)] == $past(prog_val))); // R4
    AST_COMMIT_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        p_commit |=> (((p_word ^ $past(p_word)) & ~(32'd1 << $past(prog_bit))) == '0)); // R4
    AST_COMMIT_FLAG: assert property (@(posedge clk) disable iff (rst)
        p_commit |=> p_flags[$past(prog_bit)]); // R6
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        p_reject |=> ($stable(p_word) && $stable(p_flags))); // R5

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int               NUM_WORDS  = 4096,
    parameter int               BUS_AW     = 8,
    parameter int               SERIAL_IDX = 252,
    parameter logic [31:0]      SERIAL_NUM = 32'h5EC0_1D42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              prog_err
);

    localparam int IDX_W = $clog2(NUM_WORDS);

    logic                 busy;
    logic [REG_W-1:0]     fuse_word;
    logic                 prog_req;
    logic [IDX_W-1:0]     prog_idx;
    logic [BIT_SEL_W-1:0] prog_bit;
    logic                 prog_val;

    otp_regfile #(
        .BUS_AW (BUS_AW),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .fuse_word  (fuse_word),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .prog_req   (prog_req),
        .prog_idx   (prog_idx),
        .prog_bit   (prog_bit),
        .prog_val   (prog_val)
    );

    otp_fuse_array #(
        .NUM_WORDS  (NUM_WORDS),
        .IDX_W      (IDX_W),
        .SERIAL_IDX (SERIAL_IDX),
        .SERIAL_NUM (SERIAL_NUM)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .prog_req  (prog_req),
        .prog_idx  (prog_idx),
        .prog_bit  (prog_bit),
        .prog_val  (prog_val),
        .look_idx  (prog_idx),
        .look_word (fuse_word),
        .prog_err  (prog_err),
        .busy      (busy)
    );

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> $past(bus_valid && bus_write)); // R5

endmodule

// File: tb/sim_otp_fuse_ctrl.sv
module sim_otp_fuse_ctrl;

    localparam int          CLK_P      = 10;
    localparam int          NUM_WORDS  = 4096;
    localparam int          SERIAL_IDX = 252;
    localparam logic [31:0] SERIAL_NUM = 32'h5EC0_1D42;

    localparam logic [7:0] O_ADDR   = 8'h00;
    localparam logic [7:0] O_BITSEL = 8'h04;
    localparam logic [7:0] O_REDSEL = 8'h08;
    localparam logic [7:0] O_CHIPEN = 8'h0C;
    localparam logic [7:0] O_CLOCK  = 8'h10;
    localparam logic [7:0] O_DIN    = 8'h14;
    localparam logic [7:0] O_DOUT   = 8'h18;
    localparam logic [7:0] O_STROBE = 8'h1C;
    localparam logic [7:0] O_PPULSE = 8'h20;
    localparam logic [7:0] O_TREAD  = 8'h30;
    localparam logic [7:0] O_TRIM   = 8'h34;
    localparam logic [7:0] O_PROGEN = 8'h38;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr  = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        prog_err;

    int checks = 0;
    int errors = 0;
    logic last_err;

    always #(CLK_P/2) clk = ~clk;

    otp_fuse_ctrl #(
        .NUM_WORDS  (NUM_WORDS),
        .BUS_AW     (8),
        .SERIAL_IDX (SERIAL_IDX),
        .SERIAL_NUM (SERIAL_NUM)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .prog_err   (prog_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        last_err = prog_err;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic v;
        rd(a, d, v);
        chk(tag, d, exp);
    endtask

    task automatic set_word(input logic [31:0] idx, input logic [4:0] b, input logic val);
        wr(O_ADDR, idx);
        wr(O_BITSEL, 32'(b));
        wr(O_DIN, {31'b0, val});
    endtask

    task automatic open_dout();
        wr(O_CHIPEN, 32'h1);
        wr(O_STROBE, 32'h1);
        wr(O_TRIM, 32'h1);
    endtask

    // R1: reset values and the sweep window
    task automatic t_reset();
        logic [31:0] d;
        logic v;
        wr(O_ADDR, 32'h7);          // during sweep: ignored
        wr(O_CHIPEN, 32'h1);        // ignored too
        rd(O_DOUT, d, v);
        chk("R1 dout during sweep", d, 32'h0000_00FF);
        repeat (NUM_WORDS + 4) @(negedge clk);
        rd_chk("R1 addr after reset", O_ADDR, 32'h0);
        rd_chk("R1 chipen after reset", O_CHIPEN, 32'h0);
        rd_chk("R1 progen after reset", O_PROGEN, 32'h0);
        chk("R5 no err at rest", {31'b0, prog_err}, 32'h0);
    endtask

    // R1 R2: contents left by the sweep
    task automatic t_sweep_contents();
        open_dout();
        wr(O_ADDR, 32'h0);
        rd_chk("R1 word 0", O_DOUT, 32'hFFFF_FFFF);
        wr(O_ADDR, 32'(NUM_WORDS - 1));
        rd_chk("R1 last word", O_DOUT, 32'hFFFF_FFFF);
        wr(O_ADDR, 32'(SERIAL_IDX));
        rd_chk("R2 serial word", O_DOUT, SERIAL_NUM);
        wr(O_ADDR, 32'(SERIAL_IDX + 1));
        rd_chk("R2 inverse serial word", O_DOUT, ~SERIAL_NUM);
    endtask

    // R3: each enable gates data-out
    task automatic t_gating();
        wr(O_ADDR, 32'(SERIAL_IDX));
        wr(O_CHIPEN, 32'h0);
        rd_chk("R3 chip enable off", O_DOUT, 32'h0000_00FF);
        wr(O_CHIPEN, 32'hFFFF_FFFE);
        rd_chk("R3 chip enable bit0 clear", O_DOUT, 32'h0000_00FF);
        wr(O_CHIPEN, 32'h1);
        wr(O_STROBE, 32'h0);
        rd_chk("R3 strobe off", O_DOUT, 32'h0000_00FF);
        wr(O_STROBE, 32'h1);
        wr(O_TRIM, 32'h0);
        rd_chk("R3 trim off", O_DOUT, 32'h0000_00FF);
        wr(O_TRIM, 32'h1);
        rd_chk("R3 all on", O_DOUT, SERIAL_NUM);
    endtask

    // R4 R5 R6: program, refuse, independence
    task automatic t_program();
        set_word(32'd5, 5'd3, 1'b0);
        wr(O_PROGEN, 32'h1);
        chk("R4 no err on first program", {31'b0, last_err}, 32'h0);
        rd_chk("R4 bit 3 cleared", O_DOUT, 32'hFFFF_FFF7);
        wr(O_DIN, 32'h1);
        wr(O_PROGEN, 32'h1);
        chk("R5 err pulse on re-program", {31'b0, last_err}, 32'h1);
        @(negedge clk);
        chk("R5 err pulse one cycle", {31'b0, prog_err}, 32'h0);
        rd_chk("R5 word unchanged", O_DOUT, 32'hFFFF_FFF7);
        set_word(32'd5, 5'd31, 1'b0);
        wr(O_PROGEN, 32'h1);
        chk("R6 other bit same word no err", {31'b0, last_err}, 32'h0);
        rd_chk("R6 other bit same word", O_DOUT, 32'h7FFF_FFF7);
        set_word(32'd6, 5'd3, 1'b0);
        wr(O_PROGEN, 32'h1);
        chk("R6 same bit other word no err", {31'b0, last_err}, 32'h0);
        rd_chk("R6 same bit other word", O_DOUT, 32'hFFFF_FFF7);
        wr(O_ADDR, 32'd5);
        rd_chk("R4 neighbour kept", O_DOUT, 32'h7FFF_FFF7);
    endtask

    // R7: enable bit and redundancy-select
    task automatic t_no_program();
        set_word(32'd9, 5'd0, 1'b0);
        wr(O_PROGEN, 32'hFFFF_FFFE);
        rd_chk("R7 progen stores bit0 only", O_PROGEN, 32'h0);
        rd_chk("R7 bit0 clear no program", O_DOUT, 32'hFFFF_FFFF);
        wr(O_REDSEL, 32'h1);
        wr(O_PROGEN, 32'hFFFF_FFFF);
        rd_chk("R7 progen readback", O_PROGEN, 32'h1);
        rd_chk("R7 redundancy blocks program", O_DOUT, 32'hFFFF_FFFF);
        wr(O_REDSEL, 32'h0);
        wr(O_PROGEN, 32'h1);
        chk("R7 flag was not set", {31'b0, last_err}, 32'h0);
        rd_chk("R7 later program works", O_DOUT, 32'hFFFF_FFFE);
    endtask

    // R8: data-out is read-only
    task automatic t_dout_ro();
        wr(O_ADDR, 32'(SERIAL_IDX));
        wr(O_DOUT, 32'h0);
        rd_chk("R8 dout write ignored", O_DOUT, SERIAL_NUM);
        rd_chk("R8 addr untouched", O_ADDR, 32'(SERIAL_IDX));
    endtask

    // R9: masking
    task automatic t_mask();
        wr(O_ADDR, 32'hFFFF_F005);
        rd_chk("R9 address masked", O_ADDR, 32'h0000_0005);
        wr(O_BITSEL, 32'h0000_0023);
        rd_chk("R9 bit selector masked", O_BITSEL, 32'h0000_0003);
    endtask

    // R10 R11: unmapped offsets, response timing, plain storage
    task automatic t_map();
        logic [31:0] d;
        logic v;
        wr(O_ADDR, 32'h11);
        wr(8'h01, 32'h22);
        rd_chk("R10 misaligned write ignored", O_ADDR, 32'h11);
        wr(8'h3C, 32'h33);
        rd_chk("R10 offset 0x3C reads zero", 8'h3C, 32'h0);
        rd_chk("R10 offset 0x80 reads zero", 8'h80, 32'h0);
        rd_chk("R10 misaligned read zero", 8'h01, 32'h0);
        rd_chk("R10 addr after unmapped writes", O_ADDR, 32'h11);
        wr(O_CLOCK, 32'hA5A5_5A5A);
        rd(O_CLOCK, d, v);
        chk("R11 clock readback", d, 32'hA5A5_5A5A);
        chk("R11 rvalid with data", {31'b0, v}, 32'h1);
        @(negedge clk);
        chk("R11 rvalid drops", {31'b0, bus_rvalid}, 32'h0);
        wr(O_PPULSE, 32'h8000_0001);
        rd_chk("R11 program-pulse readback", O_PPULSE, 32'h8000_0001);
        wr(O_TREAD, 32'hDEAD_BEEF);
        rd_chk("R11 test register readback", O_TREAD, 32'hDEAD_BEEF);
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sweep_contents();
        t_gating();
        t_program();
        t_no_program();
        t_dout_ro();
        t_mask();
        t_map();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule